// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt flags from a processor's on-chip peripherals, from two external request pins and from internal fault and trap events. It resolves them to one request line and a 16-bit vector address for the CPU. Every source owns a sticky flag. A flag is set by a one-cycle strobe from its peripheral and is removed only by an explicit clear strobe, which models a write of 1 to the flag bit. Each maskable source also has an arm bit. A global mask bit I, held in the block, blocks every maskable source at once. The external non-maskable pin has its own enable bit X. Software can clear X to 0, and after that it cannot set it back to 1.

The winner is chosen from a fixed order, listed from highest to lowest:

- clock-monitor fail
- watchdog failure
- the non-maskable pin
- the maskable groups
- illegal opcode
- software trap

Several maskable flags share one group and one vector. The parallel-port strobe shares the external maskable pin's vector. The five serial-port flags share the lowest group's vector. A promotion register can move one maskable group to the top of the maskable order. The other groups keep their order.

The request and the vector are registered. While the CPU holds its acknowledge high, both outputs are frozen. Flags keep collecting events during that time.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, all flags are clear, I=1, X=1 and the promotion select is 0. With nothing pending, `irq_req` is 0 and `irq_vec` is 16'hFFFE.
- R2: A maskable flag raises a request only when its arm bit in `marm` is 1 and I is 0. A flag whose arm bit is 0, or any maskable flag while I=1, leaves `irq_req` at 0.
- R3: A flag stays set until its clear strobe (`mclr`/`uclr` bit at 1) is seen. After the clear, the request it caused goes away.
- R4: When a set strobe and a clear strobe reach the same flag in the same cycle, the flag ends up set.
- R5: The maskable groups rank from highest to lowest as follows:
  - group 0: `mset` bit 0 (external pin) and bit 1 (parallel strobe), vector FFF2
  - group 1: bit 2 (real-time tick), vector FFF0
  - groups 2 to 4: bits 3 to 5 (input captures 1 to 3), vectors FFEE, FFEC, FFEA
  - groups 5 to 9: bits 6 to 10 (output compares 1 to 5), vectors FFE8 down to FFE0
  - group 10: bit 11 (timer overflow), vector FFDE
  - group 11: bit 12 (pulse-count overflow), vector FFDC
  - group 12: bit 13 (pulse edge), vector FFDA
  - group 13: bit 14 (SPI), vector FFD8
  - group 14: bits 15 to 19 (serial flags), vector FFD6

  In general, group g has vector FFF2 - 2*g.
- R6: Flags that share a group give the same vector: `mset` bits 0 and 1 both give FFF2, and bits 15 to 19 all give FFD6. Every vector raised is even and lies in FFD6..FFFC.
- R7: When `pri_wdata` = g (0..14) is written, group g, if pending, wins over all other maskable groups. The remaining groups keep their order. The value 15 promotes no group.
- R8: The `uset` flags are indexed as follows:
  - bit 0: clock-monitor fail, armed by `uarm` bit 0, vector FFFC
  - bit 1: watchdog failure, armed by `uarm` bit 1, vector FFFA
  - bit 2: non-maskable pin, vector FFF4
  - bit 3: illegal opcode, vector FFF8
  - bit 4: software trap, vector FFF6

  None of them is affected by I. Bits 0 to 2 rank above all maskable groups, and bits 3 and 4 rank below them.
- R9: The non-maskable pin flag requests only while X=0. A write to X with data 0 clears X. A later write with data 1 leaves X at 0.
- R10: While `ack` is 1, `irq_req` and `irq_vec` hold their values. Flags set or cleared in that time take effect once `ack` returns to 0.
- R11: Writing `i_wdata` with `i_wr` sets the mask bit I. A change of I shows at the outputs two clock edges after the write cycle, which is the same latency as a flag strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mset | input | 20 | Maskable flag set strobes |
| mclr | input | 20 | Maskable flag clear strobes (write-1-to-clear) |
| marm | input | 20 | Maskable arm bits |
| uset | input | 5 | Unmaskable flag set strobes |
| uclr | input | 5 | Unmaskable flag clear strobes |
| uarm | input | 2 | Arm bits for clock-monitor and watchdog sources |
| i_wr | input | 1 | Write strobe for mask bit I |
| i_wdata | input | 1 | New value of I |
| x_wr | input | 1 | Write strobe for enable X |
| x_wdata | input | 1 | New value of X (only 0 takes effect) |
| pri_wr | input | 1 | Write strobe for promotion select |
| pri_wdata | input | 4 | Promoted maskable group, 15 = none |
| ack | input | 1 | CPU acknowledge; freezes the outputs |
| irq_req | output | 1 | Registered request to the CPU |
| irq_vec | output | 16 | Registered vector address |

## Verification
The arbiter is tried with single flags, which show the latency and the vector of each group. It is also tried with pairs of flags in different groups, which separate a correct priority order from one that is reversed or offset. Pairs inside one shared group show that group members map to one vector and are not given vectors of their own. The promotion runs show that only the chosen group moves up and that the others keep their relative order. Mask, arm and X writes, together with acknowledge windows, separate gating and holding faults from arbitration faults.

// File: rtl/vint_ctrl.sv
module vint_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] mset,
  input  logic [19:0] mclr,
  input  logic [19:0] marm,
  input  logic [4:0]  uset,
  input  logic [4:0]  uclr,
  input  logic [1:0]  uarm,
  input  logic        i_wr,
  input  logic        i_wdata,
  input  logic        x_wr,
  input  logic        x_wdata,
  input  logic        pri_wr,
  input  logic [3:0]  pri_wdata,
  input  logic        ack,
  output logic        irq_req,
  output logic [15:0] irq_vec
);
  localparam int NM = 20;
  localparam int NU = 5;
  localparam int NG = 15;
  localparam logic [15:0] VIDLE = 16'hFFFE;
  localparam logic [15:0] VGRP0 = 16'hFFF2;

  logic [NM-1:0] mflag;
  logic [NU-1:0] uflag;
  logic          i_q, x_q;
  logic [3:0]    pri_q;

  logic [NM-1:0] live;
  logic [NG-1:0] gp;
  logic [15:0]   gp_ext;
  logic          win;
  logic [15:0]   vsel;

  assign live = mflag & marm & {NM{~i_q}};

  assign gp[0]      = |live[1:0];
  assign gp[NG-1]   = |live[NM-1:NG];
  for (genvar g = 1; g < NG-1; g++) begin : g_grp
    assign gp[g] = live[g+1];
  end
  assign gp_ext = {1'b0, gp};

  always_comb begin
    win  = 1'b0;
    vsel = VIDLE;
    if (uflag[4]) begin win = 1'b1; vsel = 16'hFFF6; end
    if (uflag[3]) begin win = 1'b1; vsel = 16'hFFF8; end
    for (int g = NG-1; g >= 0; g--) begin
      if (gp[g]) begin win = 1'b1; vsel = VGRP0 - 16'(2*g); end
    end
    if (gp_ext[pri_q]) begin win = 1'b1; vsel = VGRP0 - {11'd0, pri_q, 1'b0}; end
    if (uflag[2] && !x_q) begin win = 1'b1; vsel = 16'hFFF4; end
    if (uflag[1] && uarm[1]) begin win = 1'b1; vsel = 16'hFFFA; end
    if (uflag[0] && uarm[0]) begin win = 1'b1; vsel = 16'hFFFC; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mflag   <= '0;
      uflag   <= '0;
      i_q     <= 1'b1;
      x_q     <= 1'b1;
      pri_q   <= '0;
      irq_req <= 1'b0;
      irq_vec <= VIDLE;
    end else begin
      mflag <= (mflag & ~mclr) | mset;
      uflag <= (uflag & ~uclr) | uset;
      if (i_wr) i_q <= i_wdata;
      if (x_wr && !x_wdata) x_q <= 1'b0;
      if (pri_wr) pri_q <= pri_wdata;
      if (!ack) begin
        irq_req <= win;
        irq_vec <= vsel;
      end
    end
  end
endmodule

module vint_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        ack,
  input logic [19:0] mclr,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        i_q,
  input logic        x_q,
  input logic [4:0]  uflag,
  input logic [19:0] mflag
);
  p_idle_vec_r1: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_vec == 16'hFFFE);

  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (!ack && i_q && uflag == 5'd0) |=> !irq_req);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(mflag) & ~$past(mclr) & ~mflag) == 20'd0));

  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[0] == 1'b0 && irq_vec >= 16'hFFD6 && irq_vec <= 16'hFFFC));

  p_x_once_r9: assert property (@(posedge clk) disable iff (rst)
    !x_q |=> !x_q);

  p_ack_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $past(ack) |-> ($stable(irq_vec) && $stable(irq_req)));
endmodule

bind vint_ctrl vint_ctrl_chk u_chk (.*);

// File: tb/sim_vint_ctrl.sv
module sim_vint_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] mset, mclr, marm;
  logic [4:0]  uset, uclr;
  logic [1:0]  uarm;
  logic        i_wr, i_wdata, x_wr, x_wdata, pri_wr, ack;
  logic [3:0]  pri_wdata;
  logic        irq_req;
  logic [15:0] irq_vec;

  int checks = 0;
  int errors = 0;
  logic [16:0] exq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_ctrl u0 (.*);

  task automatic clear_strobes();
    mset = '0; mclr = '0; uset = '0; uclr = '0;
    i_wr = 1'b0; x_wr = 1'b0; pri_wr = 1'b0;
  endtask

  task automatic settle(input logic req, input logic [15:0] vec, input string tag);
    @(posedge clk); #1 clear_strobes();
    @(posedge clk); #1;
    exq.push_back({req, vec});
    tagq.push_back(tag);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exq.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exq.pop_front();
      t = tagq.pop_front();
      checks++;
      if ({irq_req, irq_vec} !== e) begin
        errors++;
        $display("FAIL %s: got req=%0b vec=%h expected req=%0b vec=%h",
                 t, irq_req, irq_vec, e[16], e[15:0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_strobes();
    marm = '0; uarm = '0; ack = 1'b0;
    i_wdata = 1'b0; x_wdata = 1'b0; pri_wdata = 4'd0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    settle(1'b0, 16'hFFFE, "R1 reset state");

    marm[2] = 1'b1; mset[2] = 1'b1;
    settle(1'b0, 16'hFFFE, "R2 I=1 blocks tick");
    i_wr = 1'b1; i_wdata = 1'b0;
    settle(1'b1, 16'hFFF0, "R11 I cleared exposes tick");
    settle(1'b1, 16'hFFF0, "R3 flag stays set");
    mclr[2] = 1'b1;
    settle(1'b0, 16'hFFFE, "R3 clear removes request");

    mset[3] = 1'b1;
    settle(1'b0, 16'hFFFE, "R2 unarmed capture ignored");
    marm[3] = 1'b1;
    settle(1'b1, 16'hFFEE, "R2 arming pending flag");
    mclr[3] = 1'b1;
    settle(1'b0, 16'hFFFE, "R3 clear capture");
    marm = '1;

    mset[5] = 1'b1; mset[6] = 1'b1;
    settle(1'b1, 16'hFFEA, "R5 capture3 over compare1");
    mclr[5] = 1'b1;
    settle(1'b1, 16'hFFE8, "R5 compare1 next");
    mclr[6] = 1'b1;
    settle(1'b0, 16'hFFFE, "R5 cleared");

    mset[11] = 1'b1; mclr[11] = 1'b1;
    settle(1'b1, 16'hFFDE, "R4 set wins over clear");
    mclr[11] = 1'b1;
    settle(1'b0, 16'hFFFE, "R4 cleared");

    mset[19] = 1'b1;
    settle(1'b1, 16'hFFD6, "R6 serial idle flag");
    mset[16] = 1'b1;
    settle(1'b1, 16'hFFD6, "R6 second serial flag same vector");
    mset[1] = 1'b1;
    settle(1'b1, 16'hFFF2, "R6 strobe shares pin vector");
    mclr[1] = 1'b1;
    settle(1'b1, 16'hFFD6, "R6 back to serial");
    mclr[19] = 1'b1; mclr[16] = 1'b1;
    settle(1'b0, 16'hFFFE, "R6 cleared");

    pri_wr = 1'b1; pri_wdata = 4'd10;
    mset[2] = 1'b1; mset[11] = 1'b1; mset[3] = 1'b1; mset[6] = 1'b1;
    settle(1'b1, 16'hFFDE, "R7 promoted overflow wins");
    mclr[11] = 1'b1;
    settle(1'b1, 16'hFFF0, "R7 tick next");
    mclr[2] = 1'b1;
    settle(1'b1, 16'hFFEE, "R7 order kept capture1");
    pri_wr = 1'b1; pri_wdata = 4'd5;
    settle(1'b1, 16'hFFE8, "R7 promote compare1");
    pri_wr = 1'b1; pri_wdata = 4'd15;
    settle(1'b1, 16'hFFEE, "R7 no promotion");
    mclr = '1;
    settle(1'b0, 16'hFFFE, "R7 cleared");

    uset[4] = 1'b1;
    settle(1'b1, 16'hFFF6, "R8 software trap");
    uset[3] = 1'b1;
    settle(1'b1, 16'hFFF8, "R8 illegal over trap");
    mset[4] = 1'b1;
    settle(1'b1, 16'hFFEC, "R8 maskable over illegal");
    i_wr = 1'b1; i_wdata = 1'b1;
    settle(1'b1, 16'hFFF8, "R8 illegal ignores I");
    uclr = '1; mclr = '1; i_wr = 1'b1; i_wdata = 1'b0;
    settle(1'b0, 16'hFFFE, "R8 cleared");

    uset[2] = 1'b1; mset[0] = 1'b1;
    settle(1'b1, 16'hFFF2, "R9 X=1 blocks pin");
    x_wr = 1'b1; x_wdata = 1'b0;
    settle(1'b1, 16'hFFF4, "R9 X cleared pin wins");
    x_wr = 1'b1; x_wdata = 1'b1;
    settle(1'b1, 16'hFFF4, "R9 X cannot be set");
    uset[0] = 1'b1;
    settle(1'b1, 16'hFFF4, "R8 unarmed clock monitor");
    uarm[0] = 1'b1;
    settle(1'b1, 16'hFFFC, "R8 clock monitor top");
    uarm[1] = 1'b1; uset[1] = 1'b1;
    settle(1'b1, 16'hFFFC, "R8 clock monitor over watchdog");
    uclr[0] = 1'b1;
    settle(1'b1, 16'hFFFA, "R8 watchdog over pin");
    uclr = '1; mclr = '1;
    settle(1'b0, 16'hFFFE, "R8 cleared");

    mset[10] = 1'b1;
    settle(1'b1, 16'hFFE0, "R10 compare5");
    ack = 1'b1; mset[2] = 1'b1;
    settle(1'b1, 16'hFFE0, "R10 held during ack");
    mclr[10] = 1'b1;
    settle(1'b1, 16'hFFE0, "R10 held after clear");
    ack = 1'b0;
    settle(1'b1, 16'hFFF0, "R10 flag kept through ack");
    mclr = '1;
    settle(1'b0, 16'hFFFE, "R1 idle vector again");

    repeat (2) @(negedge clk);
    if (exq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d left expected 0", exq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule